// File: doc/BRIEF.md
# DDR Four-Bank Command Timing Checker

This block watches the command bus of a four-bank DDR SDRAM device. It sees one command per rising clock edge. Each command is decoded from chip select, row strobe, column strobe, write enable, the two bank-address bits and the auto-precharge address bit. The checker keeps its own model of which banks hold an open row. It then checks every command against the minimum spacing rules between activate, read, write, precharge, refresh and mode-register commands. All limits are cycle counts set by parameters.

For each command the block reports a registered violation flag and a reason code, one clock after the command is sampled. It also reports which banks are open at all times. A command is tracked even when it is flagged, so the model keeps following what the device would do. The one exception is a read or write to an idle bank, which changes nothing. The block is a passive monitor and is meant to sit beside a memory controller in simulation or on a debug build.

Top module: `ddr_cmd_timing_chk`

## Requirements
- R1: Commands are decoded from {cs_n, ras_n, cas_n, we_n}: 0011 activate, 0101 read, 0100 write, 0010 precharge, 0001 refresh, 0000 mode-register set, 0111 no-op, 0110 burst stop. While cs_n is high the command is ignored: no flag is raised and bank status does not change.
- R2: An activate sets bit ba of bank_open_o one cycle later. A precharge with a10 low closes only bank ba. A precharge with a10 high closes all four banks whatever ba holds.
- R3: A read or write to an open bank with a10 high closes that bank. With a10 low the bank stays open.
- R4: A read or write to a bank fewer than T_RCD cycles after its activate is flagged with code 1.
- R5: An activate to a bank that is still recovering is flagged with code 2. The recovery lasts T_RP cycles after a precharge, BURST_CYC+T_RP cycles after a read with auto-precharge, and BURST_CYC+T_WR+T_RP cycles after a write with auto-precharge.
- R6: A precharge of an open bank fewer than T_RAS_MIN cycles after its activate is flagged with code 3. A precharge more than T_RAS_MAX cycles after its activate is flagged with code 13.
- R7: Two activates to the same bank fewer than T_RC cycles apart are flagged with code 4. An activate fewer than T_RRD cycles after any activate is flagged with code 5.
- R8: A precharge of a bank fewer than BURST_CYC+T_WR cycles after a write to it is flagged with code 6. A read fewer than BURST_CYC+T_WTR cycles after any write is flagged with code 7.
- R9: An activate or refresh fewer than T_RFC cycles after a refresh is flagged with code 8. Any command other than a no-op fewer than T_MRD cycles after a mode-register set is flagged with code 9.
- R10: State errors have their own codes. An activate to an open bank gives 10. A read or write to an idle bank gives 11. A refresh or mode-register set while any bank is open gives 12.
- R11: Synchronous reset clears the flag, the code and every bank's open bit. Each flag and code is registered, so it appears one cycle after its command. When several rules fail at once, one code is reported, chosen by fixed priority: 9 before all others. For an activate the order is 10, 8, 2, 4, 5. For a read or write it is 11, 1, 7. For a precharge it is 3, 13, 6. For a refresh it is 12, 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; commands sampled on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank address |
| a10 | input | 1 | Auto-precharge / all-bank select bit |
| viol_o | output | 1 | Command in the previous cycle broke a rule |
| viol_code_o | output | 4 | Reason code, 0 when no violation |
| bank_open_o | output | 4 | One bit per bank, 1 when a row is open |

## Verification
The case hardest to reach from the ports is the upper bound on row-open time. It needs a bank held open for more than T_RAS_MAX cycles, about twelve thousand with the defaults. The stimulus activates two banks two cycles apart and then idles with no-ops. It then closes one bank exactly at the bound and the other just past it. The auto-precharge recovery windows are also hard to see, because the closing happens inside a read or write. They are reached by placing the next activate one cycle inside the window and then exactly at its end.

// File: rtl/ddr_chk_pkg.sv
package ddr_chk_pkg;

  typedef enum logic [2:0] {
    CMD_NOP,
    CMD_ACT,
    CMD_RD,
    CMD_WR,
    CMD_PRE,
    CMD_REF,
    CMD_MRS,
    CMD_BST
  } cmd_e;

  typedef enum logic [3:0] {
    RSN_NONE      = 4'd0,
    RSN_RCD       = 4'd1,
    RSN_RP        = 4'd2,
    RSN_RAS_MIN   = 4'd3,
    RSN_RC        = 4'd4,
    RSN_RRD       = 4'd5,
    RSN_WR        = 4'd6,
    RSN_WTR       = 4'd7,
    RSN_RFC       = 4'd8,
    RSN_MRD       = 4'd9,
    RSN_ACT_OPEN  = 4'd10,
    RSN_RW_IDLE   = 4'd11,
    RSN_NEED_IDLE = 4'd12,
    RSN_RAS_MAX   = 4'd13
  } rsn_e;

endpackage

// File: rtl/ddr_cmd_decode.sv
module ddr_cmd_decode
  import ddr_chk_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output cmd_e cmd
);

  // Deselect folds into no-op: nothing downstream reacts to it (R1)
  always_comb begin
    if (cs_n) begin
      cmd = CMD_NOP;
    end else begin
      case ({ras_n, cas_n, we_n})
        3'b011:  cmd = CMD_ACT;
        3'b101:  cmd = CMD_RD;
        3'b100:  cmd = CMD_WR;
        3'b010:  cmd = CMD_PRE;
        3'b001:  cmd = CMD_REF;
        3'b000:  cmd = CMD_MRS;
        3'b110:  cmd = CMD_BST;
        default: cmd = CMD_NOP;
      endcase
    end
  end

endmodule

// File: rtl/ddr_countdown.sv
module ddr_countdown #(
  parameter int LOAD_VAL = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic busy
);

  localparam int W = (LOAD_VAL < 1) ? 1 : $clog2(LOAD_VAL + 1);
  localparam logic [W-1:0] LOADV = W'(LOAD_VAL);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= LOADV;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy = (cnt_q != '0);

  // Spacing windows never run longer than their programmed length (R11)
  p_cnt_bound_r11: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LOADV);

endmodule

// File: rtl/ddr_bank_track.sv
module ddr_bank_track
  import ddr_chk_pkg::*;
#(
  parameter int T_RCD     = 2,
  parameter int T_RP      = 2,
  parameter int T_RAS_MIN = 5,
  parameter int T_RAS_MAX = 12000,
  parameter int T_RC      = 7,
  parameter int T_WR      = 2,
  parameter int BURST_CYC = 2
) (
  input  logic clk,
  input  logic rst,
  input  cmd_e cmd,
  input  logic hit,
  input  logic pre_hit,
  input  logic ap,
  output logic open_o,
  output logic rp_busy_o,
  output logic wr_busy_o,
  output logic lt_rcd_o,
  output logic lt_ras_o,
  output logic gt_ras_o,
  output logic lt_rc_o
);

  localparam int AGE_MAX = T_RAS_MAX + 1;
  localparam int AGE_W   = $clog2(AGE_MAX + 1);
  localparam logic [AGE_W-1:0] AGE_MAX_V = AGE_W'(AGE_MAX);
  localparam logic [AGE_W-1:0] RCD_V     = AGE_W'(T_RCD);
  localparam logic [AGE_W-1:0] RASMIN_V  = AGE_W'(T_RAS_MIN);
  localparam logic [AGE_W-1:0] RASMAX_V  = AGE_W'(T_RAS_MAX);
  localparam logic [AGE_W-1:0] RC_V      = AGE_W'(T_RC);

  localparam int RP_WRA  = BURST_CYC + T_WR + T_RP - 1;
  localparam int RP_W    = $clog2(RP_WRA + 1);
  localparam logic [RP_W-1:0] RP_PRE_V = RP_W'(T_RP - 1);
  localparam logic [RP_W-1:0] RP_RDA_V = RP_W'(BURST_CYC + T_RP - 1);
  localparam logic [RP_W-1:0] RP_WRA_V = RP_W'(RP_WRA);

  logic             open_q;
  logic [AGE_W-1:0] age_q;
  logic [RP_W-1:0]  rp_q;
  logic             act_ev, rd_ev, wr_ev, pre_ev;

  assign act_ev = (cmd == CMD_ACT) && hit;
  assign rd_ev  = (cmd == CMD_RD)  && hit && open_q;
  assign wr_ev  = (cmd == CMD_WR)  && hit && open_q;
  assign pre_ev = (cmd == CMD_PRE) && pre_hit && open_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q <= 1'b0;
    end else if (act_ev) begin
      open_q <= 1'b1;
    end else if (pre_ev || ((rd_ev || wr_ev) && ap)) begin
      open_q <= 1'b0;
    end
  end

  // Cycles since the last activate, saturating past the row-open limit
  always_ff @(posedge clk) begin
    if (rst) begin
      age_q <= AGE_MAX_V;
    end else if (act_ev) begin
      age_q <= AGE_W'(1);
    end else if (age_q < AGE_MAX_V) begin
      age_q <= age_q + 1'b1;
    end
  end

  // Row recovery before the next activate; auto-precharge adds the burst
  always_ff @(posedge clk) begin
    if (rst) begin
      rp_q <= '0;
    end else if (pre_ev) begin
      rp_q <= RP_PRE_V;
    end else if (rd_ev && ap) begin
      rp_q <= RP_RDA_V;
    end else if (wr_ev && ap) begin
      rp_q <= RP_WRA_V;
    end else if (rp_q != '0) begin
      rp_q <= rp_q - 1'b1;
    end
  end

  ddr_countdown #(.LOAD_VAL(BURST_CYC + T_WR - 1)) u_wr_rec (
    .clk  (clk),
    .rst  (rst),
    .load (wr_ev),
    .busy (wr_busy_o)
  );

  assign open_o    = open_q;
  assign rp_busy_o = (rp_q != '0);
  assign lt_rcd_o  = (age_q < RCD_V);
  assign lt_ras_o  = (age_q < RASMIN_V);
  assign gt_ras_o  = (age_q > RASMAX_V);
  assign lt_rc_o   = (age_q < RC_V);

  p_act_opens_r2: assert property (@(posedge clk) disable iff (rst)
    (act_ev) |=> open_q);

  p_age_bound_r6: assert property (@(posedge clk) disable iff (rst)
    age_q <= AGE_MAX_V);

  p_wra_arms_rp_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_ev && ap) |=> (rp_busy_o && !open_q));

endmodule

// File: rtl/ddr_cmd_timing_chk.sv
module ddr_cmd_timing_chk
  import ddr_chk_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int T_RCD     = 2,
  parameter int T_RP      = 2,
  parameter int T_RAS_MIN = 5,
  parameter int T_RAS_MAX = 12000,
  parameter int T_RC      = 7,
  parameter int T_RRD     = 2,
  parameter int T_WR      = 2,
  parameter int T_WTR     = 1,
  parameter int T_RFC     = 8,
  parameter int T_MRD     = 2,
  parameter int BURST_CYC = 2,
  localparam int BA_W     = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cs_n,
  input  logic                 ras_n,
  input  logic                 cas_n,
  input  logic                 we_n,
  input  logic [BA_W-1:0]      ba,
  input  logic                 a10,
  output logic                 viol_o,
  output logic [3:0]           viol_code_o,
  output logic [NUM_BANKS-1:0] bank_open_o
);

  cmd_e cmd;
  logic [NUM_BANKS-1:0] hit_vec, pre_sel;
  logic [NUM_BANKS-1:0] open_vec, rp_busy, wr_busy, lt_rcd, lt_ras, gt_ras, lt_rc;
  logic rrd_busy, rfc_busy, mrd_busy, wtr_busy;
  logic wr_eff;
  rsn_e rsn_d, rsn_q;
  logic viol_q;

  ddr_cmd_decode u_dec (
    .cs_n  (cs_n),
    .ras_n (ras_n),
    .cas_n (cas_n),
    .we_n  (we_n),
    .cmd   (cmd)
  );

  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
    assign hit_vec[i] = (ba == BA_W'(i));
    assign pre_sel[i] = a10 | hit_vec[i];

    ddr_bank_track #(
      .T_RCD     (T_RCD),
      .T_RP      (T_RP),
      .T_RAS_MIN (T_RAS_MIN),
      .T_RAS_MAX (T_RAS_MAX),
      .T_RC      (T_RC),
      .T_WR      (T_WR),
      .BURST_CYC (BURST_CYC)
    ) u_bank (
      .clk       (clk),
      .rst       (rst),
      .cmd       (cmd),
      .hit       (hit_vec[i]),
      .pre_hit   (pre_sel[i]),
      .ap        (a10),
      .open_o    (open_vec[i]),
      .rp_busy_o (rp_busy[i]),
      .wr_busy_o (wr_busy[i]),
      .lt_rcd_o  (lt_rcd[i]),
      .lt_ras_o  (lt_ras[i]),
      .gt_ras_o  (gt_ras[i]),
      .lt_rc_o   (lt_rc[i])
    );
  end

  assign wr_eff = (cmd == CMD_WR) && |(hit_vec & open_vec);

  // Device-wide spacing windows
  ddr_countdown #(.LOAD_VAL(T_RRD - 1)) u_rrd (
    .clk (clk), .rst (rst), .load (cmd == CMD_ACT), .busy (rrd_busy));
  ddr_countdown #(.LOAD_VAL(T_RFC - 1)) u_rfc (
    .clk (clk), .rst (rst), .load (cmd == CMD_REF), .busy (rfc_busy));
  ddr_countdown #(.LOAD_VAL(T_MRD - 1)) u_mrd (
    .clk (clk), .rst (rst), .load (cmd == CMD_MRS), .busy (mrd_busy));
  ddr_countdown #(.LOAD_VAL(BURST_CYC + T_WTR - 1)) u_wtr (
    .clk (clk), .rst (rst), .load (wr_eff), .busy (wtr_busy));

  // Rule priority: mode-register spacing first, then per command
  always_comb begin
    logic [NUM_BANKS-1:0] pm;
    pm    = pre_sel & open_vec;
    rsn_d = RSN_NONE;
    if (cmd != CMD_NOP && mrd_busy) begin
      rsn_d = RSN_MRD;
    end else begin
      case (cmd)
        CMD_ACT: begin
          if (|(hit_vec & open_vec))     rsn_d = RSN_ACT_OPEN;
          else if (rfc_busy)             rsn_d = RSN_RFC;
          else if (|(hit_vec & rp_busy)) rsn_d = RSN_RP;
          else if (|(hit_vec & lt_rc))   rsn_d = RSN_RC;
          else if (rrd_busy)             rsn_d = RSN_RRD;
        end
        CMD_RD, CMD_WR: begin
          if (!(|(hit_vec & open_vec)))      rsn_d = RSN_RW_IDLE;
          else if (|(hit_vec & lt_rcd))      rsn_d = RSN_RCD;
          else if (cmd == CMD_RD && wtr_busy) rsn_d = RSN_WTR;
        end
        CMD_PRE: begin
          if (|(pm & lt_ras))       rsn_d = RSN_RAS_MIN;
          else if (|(pm & gt_ras))  rsn_d = RSN_RAS_MAX;
          else if (|(pm & wr_busy)) rsn_d = RSN_WR;
        end
        CMD_REF: begin
          if (|open_vec)     rsn_d = RSN_NEED_IDLE;
          else if (rfc_busy) rsn_d = RSN_RFC;
        end
        CMD_MRS: begin
          if (|open_vec) rsn_d = RSN_NEED_IDLE;
        end
        default: rsn_d = RSN_NONE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      viol_q <= 1'b0;
      rsn_q  <= RSN_NONE;
    end else begin
      viol_q <= (rsn_d != RSN_NONE);
      rsn_q  <= rsn_d;
    end
  end

  assign viol_o      = viol_q;
  assign viol_code_o = rsn_q;
  assign bank_open_o = open_vec;

  p_deselect_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    (cs_n) |=> (!viol_o && bank_open_o == $past(bank_open_o)));

  p_pre_all_r2: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && !ras_n && cas_n && !we_n && a10) |=> (bank_open_o == '0));

  p_ap_closes_r3: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && ras_n && !cas_n && a10) |=> !bank_open_o[$past(ba)]);

  p_flag_code_r11: assert property (@(posedge clk) disable iff (rst)
    viol_o == (viol_code_o != 4'd0));

endmodule

// File: tb/ddr_cmd_timing_chk_tb.sv
`timescale 1ns/1ps
module ddr_cmd_timing_chk_tb;

  localparam int RASMAX = 12000;
  localparam logic [3:0] C_ACT = 4'b0011, C_RD = 4'b0101, C_WR = 4'b0100,
                         C_PRE = 4'b0010, C_REF = 4'b0001, C_MRS = 4'b0000,
                         C_NOP = 4'b0111, C_DES = 4'b1111;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b0, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0] ba = '0;
  logic a10 = 1'b0;
  logic viol_o;
  logic [3:0] viol_code_o, bank_open_o;
  int checks = 0, failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ddr_cmd_timing_chk u_dut (
    .clk (clk), .rst (rst), .cs_n (cs_n), .ras_n (ras_n), .cas_n (cas_n),
    .we_n (we_n), .ba (ba), .a10 (a10), .viol_o (viol_o),
    .viol_code_o (viol_code_o), .bank_open_o (bank_open_o)
  );

  // {req, cmd, ba, a10, exp_viol, exp_code, exp_open}
  localparam logic [19:0] VEC [0:23] = '{
    {4'd9,  C_MRS, 2'd0, 1'b0, 1'b0, 4'd0,  4'b0000}, // R9 mode set
    {4'd9,  C_NOP, 2'd0, 1'b0, 1'b0, 4'd0,  4'b0000}, // R9 no-op exempt
    {4'd2,  C_ACT, 2'd0, 1'b0, 1'b0, 4'd0,  4'b0001}, // R2 open bank 0
    {4'd7,  C_ACT, 2'd1, 1'b0, 1'b1, 4'd5,  4'b0011}, // R7 act-act other bank
    {4'd4,  C_RD,  2'd0, 1'b0, 1'b0, 4'd0,  4'b0011}, // R4 read at limit
    {4'd8,  C_WR,  2'd1, 1'b0, 1'b0, 4'd0,  4'b0011}, // R8 write
    {4'd8,  C_RD,  2'd0, 1'b0, 1'b1, 4'd7,  4'b0011}, // R8 write-to-read
    {4'd1,  C_NOP, 2'd0, 1'b0, 1'b0, 4'd0,  4'b0011}, // R1
    {4'd8,  C_RD,  2'd0, 1'b0, 1'b0, 4'd0,  4'b0011}, // R8 read at limit
    {4'd6,  C_PRE, 2'd1, 1'b0, 1'b0, 4'd0,  4'b0001}, // R6 clean precharge
    {4'd5,  C_ACT, 2'd1, 1'b0, 1'b1, 4'd2,  4'b0011}, // R5 too soon
    {4'd4,  C_WR,  2'd1, 1'b0, 1'b1, 4'd1,  4'b0011}, // R4 act-to-write
    {4'd6,  C_PRE, 2'd1, 1'b0, 1'b1, 4'd3,  4'b0001}, // R6 row too young
    {4'd10, C_RD,  2'd1, 1'b0, 1'b1, 4'd11, 4'b0001}, // R10 idle bank
    {4'd10, C_REF, 2'd0, 1'b0, 1'b1, 4'd12, 4'b0001}, // R10 refresh open
    {4'd9,  C_ACT, 2'd2, 1'b0, 1'b1, 4'd8,  4'b0101}, // R9 refresh spacing
    {4'd2,  C_PRE, 2'd3, 1'b1, 1'b1, 4'd3,  4'b0000}, // R2 all-bank close
    {4'd11, C_ACT, 2'd0, 1'b0, 1'b1, 4'd8,  4'b0001}, // R11 priority
    {4'd10, C_ACT, 2'd0, 1'b0, 1'b1, 4'd10, 4'b0001}, // R10 act open
    {4'd1,  C_DES, 2'd0, 1'b1, 1'b0, 4'd0,  4'b0001}, // R1 deselect
    {4'd3,  C_RD,  2'd0, 1'b1, 1'b0, 4'd0,  4'b0000}, // R3 auto-precharge
    {4'd1,  C_NOP, 2'd0, 1'b0, 1'b0, 4'd0,  4'b0000}, // R1
    {4'd1,  C_NOP, 2'd0, 1'b0, 1'b0, 4'd0,  4'b0000}, // R1
    {4'd5,  C_ACT, 2'd0, 1'b0, 1'b1, 4'd2,  4'b0001}  // R5 read AP window
  };

  task automatic check(input logic ev, input logic [3:0] ec,
                       input logic [3:0] eo, input int req);
    checks++;
    if (viol_o !== ev || viol_code_o !== ec || bank_open_o !== eo) begin
      failures++;
      $display("FAIL R%0d: viol=%0b code=%0d open=%b expected viol=%0b code=%0d open=%b",
               req, viol_o, viol_code_o, bank_open_o, ev, ec, eo);
    end
  endtask

  task automatic step(input logic [3:0] c, input logic [1:0] b, input logic ap,
                      input logic ev, input logic [3:0] ec, input logic [3:0] eo,
                      input int req);
    {cs_n, ras_n, cas_n, we_n} = c;
    ba  = b;
    a10 = ap;
    @(negedge clk);
    check(ev, ec, eo, req);
    {cs_n, ras_n, cas_n, we_n} = C_NOP;
    a10 = 1'b0;
  endtask

  task automatic nops(input int n);
    {cs_n, ras_n, cas_n, we_n} = C_NOP;
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    {cs_n, ras_n, cas_n, we_n} = C_NOP;
    repeat (2) @(negedge clk);
    check(1'b0, 4'd0, 4'b0000, 11); // R11 reset state
    rst = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    do_reset();

    for (int i = 0; i < 24; i++) begin
      step(VEC[i][15:12], VEC[i][11:10], VEC[i][9], VEC[i][8],
           VEC[i][7:4], VEC[i][3:0], int'(VEC[i][19:16]));
    end

    // R7: same-bank re-activate inside the row cycle after read auto-precharge
    do_reset();
    step(C_ACT, 2'd2, 1'b0, 1'b0, 4'd0, 4'b0100, 7);
    nops(1);
    step(C_RD,  2'd2, 1'b1, 1'b0, 4'd0, 4'b0000, 3);
    nops(3);
    step(C_ACT, 2'd2, 1'b0, 1'b1, 4'd4, 4'b0100, 7);

    // R5: write auto-precharge window, one cycle inside, then at its end
    do_reset();
    step(C_ACT, 2'd3, 1'b0, 1'b0, 4'd0, 4'b1000, 5);
    nops(1);
    step(C_WR,  2'd3, 1'b1, 1'b0, 4'd0, 4'b0000, 3);
    nops(4);
    step(C_ACT, 2'd3, 1'b0, 1'b1, 4'd2, 4'b1000, 5);
    do_reset();
    step(C_ACT, 2'd3, 1'b0, 1'b0, 4'd0, 4'b1000, 5);
    nops(1);
    step(C_WR,  2'd3, 1'b1, 1'b0, 4'd0, 4'b0000, 5);
    nops(5);
    step(C_ACT, 2'd3, 1'b0, 1'b0, 4'd0, 4'b1000, 5);

    // R8 write recovery; R2 single-bank precharge leaves bank 0 open
    do_reset();
    step(C_ACT, 2'd0, 1'b0, 1'b0, 4'd0, 4'b0001, 2);
    nops(1);
    step(C_ACT, 2'd1, 1'b0, 1'b0, 4'd0, 4'b0011, 7);
    nops(1);
    step(C_WR,  2'd1, 1'b0, 1'b0, 4'd0, 4'b0011, 3);
    nops(2);
    step(C_PRE, 2'd1, 1'b0, 1'b1, 4'd6, 4'b0001, 8);

    // R6 row-open upper bound: exactly at the limit, then past it
    do_reset();
    step(C_ACT, 2'd0, 1'b0, 1'b0, 4'd0, 4'b0001, 6);
    nops(1);
    step(C_ACT, 2'd1, 1'b0, 1'b0, 4'd0, 4'b0011, 6);
    nops(RASMAX - 1);
    step(C_PRE, 2'd1, 1'b0, 1'b0, 4'd0, 4'b0001, 6);
    step(C_PRE, 2'd0, 1'b0, 1'b1, 4'd13, 4'b0000, 6);

    // R10 mode set with an open bank
    do_reset();
    step(C_ACT, 2'd2, 1'b0, 1'b0, 4'd0, 4'b0100, 10);
    step(C_MRS, 2'd0, 1'b0, 1'b1, 4'd12, 4'b0100, 10);

    // R9 command straight after mode set
    do_reset();
    step(C_MRS, 2'd0, 1'b0, 1'b0, 4'd0, 4'b0000, 9);
    step(C_ACT, 2'd0, 1'b0, 1'b1, 4'd9, 4'b0001, 9);

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule